// File: doc/BRIEF.md
# Clock divider network with synthesizer bypass

This block sits behind a high-rate oscillator and turns it into a set of output clocks. A group of identical main channels runs at the oscillator rate divided by 5, which is 125 MHz from a 625 MHz oscillator. One extra channel divides by 5 or by 4 depending on a frequency-select bit, giving 125 MHz or 156.25 MHz. A slow clock is the main clock divided by 32, which is 3.90625 MHz. A feedback clock divides the oscillator by 25 so that an external phase comparator can lock a 625 MHz oscillator to a 25 MHz reference. Every divided clock aims at 50% duty, the odd ratios included.

A two-bit mode code picks how the loop is used. It can lock to a crystal reference or to an external clock input. It can also skip the loop: in that case the oscillator is switched off and the external clock goes straight to the main and selectable channels. The block drives an oscillator-enable line and a reference-select line that the analog part uses.

Top module: `clk_divnet`

## Requirements
- R1: With the loop active, every main channel output has a period of 5 oscillator cycles. It is high for 2.5 cycles: it rises half a cycle after the first rising edge of each period and falls on the third following rising edge.
- R2: With the loop active, the feedback output has a period of 25 oscillator cycles and stays high for 12.5 of them.
- R3: With the loop active, the selectable channel divides the oscillator by 5 (high 2.5 cycles) while the select bit is 0 and by 4 (high 2 cycles) while it is 1.
- R4: A change of the select bit takes effect only when the selectable divider finishes a period. No high or low phase on that channel is shorter than two oscillator cycles.
- R5: The slow output toggles on every 16th rising edge of the main channel clock, giving the main clock divided by 32. It starts low after reset.
- R6: Mode code 01 selects the crystal reference: reference-select is 1 and oscillator-enable is 1. Codes 10 and 11 select the external clock input: reference-select is 0 and oscillator-enable is 1.
- R7: Mode code 00 is bypass. Oscillator-enable and reference-select are 0. The main and selectable channels follow the external clock input directly. The feedback output stays low. The slow output counts rising edges of the external clock input.
- R8: While reset is low, all divider outputs are low and the slow divider is cleared at once. After release, the main divider starts a period at the first oscillator rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | High-rate oscillator clock |
| ref_clk | input | 1 | External clock input, passed through in bypass |
| rst_n | input | 1 | Active-low reset, synchronous to osc_clk (slow divider clears at once) |
| mode | input | 2 | Source / bypass code (00 bypass, 01 crystal, 10 and 11 external) |
| fsel | input | 1 | Selectable channel rate: 0 divides by 5, 1 divides by 4 |
| clk_main | output | NUM_MAIN | Main channel clocks |
| clk_sel | output | 1 | Selectable-rate channel clock |
| clk_slow | output | 1 | Main clock divided by 32 |
| clk_fb | output | 1 | Oscillator divided by 25, for the phase comparator |
| osc_en | output | 1 | Oscillator and loop enable |
| ref_sel | output | 1 | 1 selects the crystal reference, 0 the external input |

## Verification
Two events can land on the same oscillator edge: a change of the select bit and the terminal count of the selectable divider. The bench toggles the select bit after waits of 7 to 18 cycles, so the toggle falls on every phase of both the 4 and the 5 period, including the wrap edge itself. A behavioural model decides which ratio governs each period, and a run-length monitor on the output checks that no phase shorter than two cycles appears across the switch.

// File: rtl/clk_divnet_pkg.sv
// Shared types for the clock divider network.
package clk_divnet_pkg;

    // Source / bypass code carried on the mode input.
    typedef enum logic [1:0] {
        MODE_BYPASS  = 2'b00,
        MODE_XTAL    = 2'b01,
        MODE_EXT     = 2'b10,
        MODE_EXT_ALT = 2'b11
    } src_mode_e;

endpackage

// File: rtl/clkdiv_mode_dec.sv
// Decodes the source / bypass code into loop controls.
// Assumes the code is a static strap; purely combinational.
module clkdiv_mode_dec
    import clk_divnet_pkg::*;
(
    input  src_mode_e mode,
    output logic      bypass,
    output logic      osc_en,
    output logic      ref_sel
);

    // Map each code onto bypass, oscillator enable and reference choice.
    always_comb begin
        bypass  = 1'b0;
        osc_en  = 1'b1;
        ref_sel = 1'b0;
        unique case (mode)
            MODE_BYPASS: begin
                bypass = 1'b1;
                osc_en = 1'b0;
            end
            MODE_XTAL:    ref_sel = 1'b1;
            MODE_EXT:     ref_sel = 1'b0;
            MODE_EXT_ALT: ref_sel = 1'b0;
            default:      ref_sel = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkdiv_fixed.sv
// Fixed-ratio clock divider with 50% duty for odd and even ratios.
// An odd ratio ANDs the rising-edge phase flop with a copy delayed by
// half a cycle, which trims the high phase from HIGH to HIGH-0.5 cycles.
// Assumes RATIO >= 2. Held cleared while rst_n is low or run is low.
module clkdiv_fixed #(
    parameter int RATIO = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic clk_out
);

    localparam int CW   = $clog2(RATIO);
    localparam int HIGH = (RATIO + 1) / 2;
    localparam bit ODD  = (RATIO % 2) == 1;

    logic [CW-1:0] cnt_q;
    logic          rise_q;
    logic [CW:0]   hi_run_q;

    // Phase counter and rising-edge phase flop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            rise_q <= 1'b0;
        end else begin
            rise_q <= (cnt_q < CW'(HIGH));
            cnt_q  <= (cnt_q == CW'(RATIO - 1)) ? '0 : cnt_q + CW'(1);
        end
    end

    generate
        if (ODD) begin : g_odd
            logic fall_q;
            // Half-cycle delayed copy of the phase flop.
            always_ff @(negedge clk) begin
                if (!rst_n || !run) fall_q <= 1'b0;
                else                fall_q <= rise_q;
            end
            assign clk_out = rise_q & fall_q;
        end else begin : g_even
            assign clk_out = rise_q;
        end
    endgenerate

    // Length of the current high run of the phase flop, for checking.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) hi_run_q <= '0;
        else if (rise_q)    hi_run_q <= hi_run_q + (CW+1)'(1);
        else                hi_run_q <= '0;
    end

    // R1, R2
    fixed_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run_q <= (CW+1)'(HIGH));

endmodule

// File: rtl/clkdiv_sel.sv
// Two-ratio clock divider: RATIO_A while sel_b is 0, RATIO_B while 1.
// The ratio is latched only when a period ends, so no short phase appears.
// Duty trimming for odd ratios works as in clkdiv_fixed.
module clkdiv_sel #(
    parameter int RATIO_A = 5,
    parameter int RATIO_B = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_b,
    output logic clk_out
);

    localparam int MAXR     = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
    localparam int CW       = $clog2(MAXR);
    localparam int HIGH_A   = (RATIO_A + 1) / 2;
    localparam int HIGH_B   = (RATIO_B + 1) / 2;
    localparam int HIGH_MAX = (HIGH_A > HIGH_B) ? HIGH_A : HIGH_B;
    localparam bit ODD_A    = (RATIO_A % 2) == 1;
    localparam bit ODD_B    = (RATIO_B % 2) == 1;

    logic [CW-1:0] cnt_q;
    logic          ratio_b_q;
    logic          rise_q;
    logic          fall_q;
    logic [CW-1:0] cur_last;
    logic [CW-1:0] cur_high;
    logic          cur_odd;
    logic [CW:0]   hi_run_q;

    // Terminal count, high length and duty mode of the active ratio.
    always_comb begin
        cur_last = ratio_b_q ? CW'(RATIO_B - 1) : CW'(RATIO_A - 1);
        cur_high = ratio_b_q ? CW'(HIGH_B)      : CW'(HIGH_A);
        cur_odd  = ratio_b_q ? ODD_B            : ODD_A;
    end

    // Phase counter, ratio latch at period end, rising-edge phase flop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q     <= '0;
            rise_q    <= 1'b0;
            ratio_b_q <= sel_b;
        end else begin
            rise_q <= (cnt_q < cur_high);
            if (cnt_q == cur_last) begin
                cnt_q     <= '0;
                ratio_b_q <= sel_b;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // Half-cycle delayed copy of the phase flop.
    always_ff @(negedge clk) begin
        if (!rst_n || !run) fall_q <= 1'b0;
        else                fall_q <= rise_q;
    end

    assign clk_out = cur_odd ? (rise_q & fall_q) : rise_q;

    // Length of the current high run of the phase flop, for checking.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) hi_run_q <= '0;
        else if (rise_q)    hi_run_q <= hi_run_q + (CW+1)'(1);
        else                hi_run_q <= '0;
    end

    // R4
    ratio_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n || !run)
        (ratio_b_q != $past(ratio_b_q)) |-> (cnt_q == '0));

    // R3
    sel_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run_q <= (CW+1)'(HIGH_MAX));

endmodule

// File: rtl/clkdiv_slow.sv
// Power-of-two divider clocked by the main channel clock.
// Assumes DIV is a power of two. Its clock stops in reset, so the reset
// clears it at once instead of on an edge.
module clkdiv_slow #(
    parameter int DIV = 32
) (
    input  logic src_clk,
    input  logic rst_n,
    output logic clk_out
);

    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt_q;

    // Free-running edge counter; its top bit is the divided clock.
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CW'(1);
    end

    assign clk_out = cnt_q[CW-1];

endmodule

// File: rtl/clk_divnet.sv
// Clock divider network: main group, selectable channel, slow clock,
// feedback clock and source / bypass decode.
// Assumes mode changes only while rst_n is low; the bypass mux does not
// re-time the switch between the oscillator and the external input.
module clk_divnet
    import clk_divnet_pkg::*;
#(
    parameter int NUM_MAIN   = 4,
    parameter int MAIN_DIV   = 5,
    parameter int FB_DIV     = 25,
    parameter int SEL_DIV_LO = 5,
    parameter int SEL_DIV_HI = 4,
    parameter int SLOW_DIV   = 32
) (
    input  logic                osc_clk,
    input  logic                ref_clk,
    input  logic                rst_n,
    input  logic [1:0]          mode,
    input  logic                fsel,
    output logic [NUM_MAIN-1:0] clk_main,
    output logic                clk_sel,
    output logic                clk_slow,
    output logic                clk_fb,
    output logic                osc_en,
    output logic                ref_sel
);

    logic bypass;
    logic run;
    logic div_main;
    logic div_sel;
    logic div_fb;
    logic src_main;

    clkdiv_mode_dec u_dec (
        .mode    (src_mode_e'(mode)),
        .bypass  (bypass),
        .osc_en  (osc_en),
        .ref_sel (ref_sel)
    );

    assign run = !bypass;

    clkdiv_fixed #(.RATIO(MAIN_DIV)) u_main (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .run     (run),
        .clk_out (div_main)
    );

    clkdiv_fixed #(.RATIO(FB_DIV)) u_fb (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .run     (run),
        .clk_out (div_fb)
    );

    clkdiv_sel #(.RATIO_A(SEL_DIV_LO), .RATIO_B(SEL_DIV_HI)) u_sel (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .run     (run),
        .sel_b   (fsel),
        .clk_out (div_sel)
    );

    assign src_main = bypass ? ref_clk : div_main;

    clkdiv_slow #(.DIV(SLOW_DIV)) u_slow (
        .src_clk (src_main),
        .rst_n   (rst_n),
        .clk_out (clk_slow)
    );

    // Fan the main source out to every main channel.
    generate
        for (genvar i = 0; i < NUM_MAIN; i++) begin : g_main
            assign clk_main[i] = src_main;
        end
    endgenerate

    assign clk_sel = bypass ? ref_clk : div_sel;
    assign clk_fb  = div_fb;

    // R7
    bypass_fb_quiet_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (bypass && $past(bypass)) |-> !clk_fb);

    // R6
    xtal_needs_osc_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ref_sel |-> osc_en);

endmodule

// File: tb/sim_clk_divnet.sv
// Bench: behavioural reference model compared on both clock phases.
module sim_clk_divnet;

    localparam int NM = 4;

    logic          osc_clk = 1'b0;
    logic          ref_clk = 1'b0;
    logic          rst_n   = 1'b1;
    logic [1:0]    mode    = 2'b01;
    logic          fsel    = 1'b0;
    logic [NM-1:0] clk_main;
    logic          clk_sel, clk_slow, clk_fb, osc_en, ref_sel;

    clk_divnet #(.NUM_MAIN(NM)) u0 (
        .osc_clk  (osc_clk),
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .fsel     (fsel),
        .clk_main (clk_main),
        .clk_sel  (clk_sel),
        .clk_slow (clk_slow),
        .clk_fb   (clk_fb),
        .osc_en   (osc_en),
        .ref_sel  (ref_sel)
    );

    // 50 MHz oscillator stand-in; external input with an unrelated period.
    always #10 osc_clk = ~osc_clk;
    initial begin
        #7;
        forever begin
            ref_clk = ~ref_clk;
            #30;
        end
    end

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    // Model state
    int e_cnt = -1;
    int s_cnt = 0;
    int s_ratio = 5;
    int slow_cnt = 0;
    bit m_r = 0, m_n = 0, f_r = 0, f_n = 0, s_r = 0, s_n = 0;
    bit m_val = 0, f_val = 0, s_val = 0, last_main = 0;
    // R4 run-length monitor
    bit track = 0, first_done = 0, last_sel = 0;
    int run_len = 0;

    function automatic bit phase_hi(int e, int n);
        return (e >= 0) && ((e % n) < (n + 1) / 2);
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic note_main(bit v);
        if (v && !last_main && rst_n && mode != 2'b00) slow_cnt++;
        last_main = v;
    endtask

    // Model update on rising oscillator edges.
    always @(posedge osc_clk) begin
        bit run;
        run = rst_n && (mode != 2'b00);
        if (!run) e_cnt = -1;
        else      e_cnt++;
        m_r = phase_hi(e_cnt, 5);
        f_r = phase_hi(e_cnt, 25);
        if (!run) begin
            s_r = 0;
            s_cnt = 0;
            s_ratio = fsel ? 4 : 5;
        end else begin
            s_r = (s_cnt < (s_ratio + 1) / 2);
            if (s_cnt == s_ratio - 1) begin
                s_cnt = 0;
                s_ratio = fsel ? 4 : 5;
            end else begin
                s_cnt++;
            end
        end
        m_val = m_r & m_n;
        f_val = f_r & f_n;
        s_val = (s_ratio % 2 == 1) ? (s_r & s_n) : s_r;
        if (!rst_n) slow_cnt = 0;
        note_main(m_val);
    end

    // Model update on falling oscillator edges.
    always @(negedge osc_clk) begin
        bit run;
        run = rst_n && (mode != 2'b00);
        m_n = run ? m_r : 1'b0;
        f_n = run ? f_r : 1'b0;
        s_n = run ? s_r : 1'b0;
        m_val = m_r & m_n;
        f_val = f_r & f_n;
        s_val = (s_ratio % 2 == 1) ? (s_r & s_n) : s_r;
        if (!rst_n) slow_cnt = 0;
        note_main(m_val);
    end

    always @(posedge ref_clk) if (rst_n && mode == 2'b00) slow_cnt++;
    always @(negedge rst_n) slow_cnt = 0;

    task automatic compare();
        bit byp;
        logic exp_main;
        string tg;
        byp = (mode == 2'b00);
        exp_main = byp ? ref_clk : m_val;
        tg = !rst_n ? "R8" : (byp ? "R7" : "R1");
        for (int i = 0; i < NM; i++) chk(tg, "main", clk_main[i], exp_main);
        chk(!rst_n ? "R8" : (byp ? "R7" : "R3"), "sel", clk_sel, byp ? ref_clk : s_val);
        chk(!rst_n ? "R8" : (byp ? "R7" : "R2"), "fb", clk_fb, f_val);
        chk(!rst_n ? "R8" : "R5", "slow", clk_slow, (slow_cnt % 32) >= 16);
        chk(byp ? "R7" : "R6", "osc_en", osc_en, !byp);
        chk(byp ? "R7" : "R6", "ref_sel", ref_sel, mode == 2'b01);
        // R4: no short phase on the selectable channel while running
        if (rst_n && !byp) begin
            if (!track) begin
                track = 1;
                first_done = 0;
                last_sel = clk_sel;
                run_len = 1;
            end else if (clk_sel == last_sel) begin
                run_len++;
            end else begin
                if (first_done) begin
                    checks++;
                    if (run_len < 4) begin
                        errors++;
                        $display("FAIL R4 sel phase length: actual %0d expected >=4 half-cycles at %0t",
                                 run_len, $time);
                    end
                end
                first_done = 1;
                last_sel = clk_sel;
                run_len = 1;
            end
        end else begin
            track = 0;
        end
    endtask

    // Sample away from both oscillator edges.
    always @(posedge osc_clk) begin
        #5;
        if (started && !done) compare();
    end
    always @(negedge osc_clk) begin
        #5;
        if (started && !done) compare();
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge osc_clk);
        #3;
    endtask

    task automatic restart(logic [1:0] m, logic f, int hold);
        rst_n = 1'b0;
        wait_cyc(3);
        mode = m;
        fsel = f;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(hold);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        wait_cyc(2);
        started = 1;
        wait_cyc(4);                 // R8 reset state compared each phase
        rst_n = 1'b1;
        wait_cyc(400);               // R1 R2 R3 R5 R6 crystal mode
        for (int k = 1; k <= 12; k++) begin
            fsel = ~fsel;            // R4 toggles at every divider phase
            wait_cyc(k + 6);
        end
        wait_cyc(60);
        rst_n = 1'b0;                // R8 reset pulse mid-run
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(80);
        restart(2'b10, 1'b0, 200);   // R6 external input
        restart(2'b11, 1'b1, 200);   // R6 alias code, divide by 4
        restart(2'b00, 1'b0, 300);   // R7 bypass
        restart(2'b01, 1'b1, 200);   // back to crystal
        done = 1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        #3_000_000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R8 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule